// File: doc/BRIEF.md
# DMA Operand Packing Buffer

This block sits on the data path of a two-cycle (read, then write) DMA channel. It gathers source operands of one width into a 32-bit staging register and releases destination operands of another width. Narrow reads are packed into one wide write, and one wide read is unpacked into several narrow writes. Equal widths pass straight through. The staging register has no software address. Only the channel sequencer reaches it, through request and strobe pairs.

On the read side, the block raises `rd_req` when it can take another source operand. The sequencer then runs the bus read and pulses `rd_valid` with the operand on `rd_data`. On the write side, the block raises `wr_req` once a full destination operand is staged. It keeps `wr_data` and `wr_size` steady until the sequencer pulses `wr_ack`. Data is kept in big-endian order: the earliest byte read always leaves in the most significant position of the next write. Address generation, byte counting and single-cycle transfers are handled elsewhere.

Top module: `dpk_holding_reg`

## Requirements
- R1: After reset, and in the cycle after `abort` is sampled high, the buffer is empty: `rd_req`=1 and `wr_req`=0.
- R2: Size codes are 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, and 3 = 32 bits. Operands are right-justified on `rd_data` and `wr_data`. Bits of `rd_data` above the source operand are ignored. Bits of `wr_data` above the destination operand are zero.
- R3: When the destination is wider than the source, exactly dst/src reads are accepted before each write. The first byte read appears in the most significant byte of that write.
- R4: When the source is wider than the destination, each read is followed by exactly src/dst writes. The most significant part of the read is written first.
- R5: When the two sizes are equal, each read is followed by exactly one write carrying the same operand.
- R6: `rd_req` and `wr_req` are never high together. No read is requested while a write is pending.
- R7: A `rd_valid` pulse while `rd_req`=0 has no effect, and a `wr_ack` pulse while `wr_req`=0 has no effect.
- R8: While `wr_req`=1 and no `wr_ack` or `abort` arrives, `wr_data` holds its value and `wr_req` stays high.
- R9: While `wr_req`=1, `wr_size` equals `dst_size`.
- R10: An abort discards partly packed data. The next write carries only bytes read after the abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| abort | input | 1 | Synchronous flush of the staged data |
| src_size | input | 2 | Source operand size code |
| dst_size | input | 2 | Destination operand size code |
| rd_req | output | 1 | Ready to accept a source operand |
| rd_valid | input | 1 | Source operand strobe |
| rd_data | input | 32 | Source operand, right-justified |
| wr_req | output | 1 | Destination operand staged and waiting |
| wr_ack | input | 1 | Destination write accepted |
| wr_data | output | 32 | Destination operand, right-justified |
| wr_size | output | 2 | Size code of the pending write |

## Verification
The case hardest to reach from the ports is a stray strobe that arrives on the side that is not requesting. Examples are a `rd_valid` with junk data while a write is pending, or a `wr_ack` in the middle of packing. Correct designs hide such strobes, so only a misbehaving design shows their effect. The bench sweeps all sixteen size-code pairs and walks eight bytes of a numbered byte stream through each pair. Stray strobes and idle cycles are injected at fixed step positions, and the bench predicts request levels and write data from running counts of bytes read and written. An abort in the middle of packing is driven separately, and the bench confirms that the stale bytes never reach a write.

// File: rtl/dpk_pkg.sv
package dpk_pkg;

   // Bytes carried by a size code, capped at the buffer's lane count.
   function automatic logic [3:0] code_to_bytes(input logic [1:0] code, input int lanes);
      logic [3:0] b;
      b = 4'd1 << code;
      if (int'(b) > lanes) b = lanes[3:0];
      return b;
   endfunction

endpackage

// File: rtl/dpk_insert.sv
// Merges a right-justified source operand into the lanes just below the filled ones.
module dpk_insert #(
   parameter int LANE_W = 8,
   parameter int LANES  = 4,
   parameter int CNT_W  = 3
) (
   input  logic [LANE_W*LANES-1:0] hold_q,
   input  logic [CNT_W-1:0]        fill,
   input  logic [CNT_W-1:0]        nbytes,
   input  logic [LANE_W*LANES-1:0] opnd,
   output logic [LANE_W*LANES-1:0] hold_d
);
   localparam int DATA_W = LANE_W * LANES;

   for (genvar L = 0; L < LANES; L++) begin : g_lane
      logic             in_rng;
      logic [CNT_W-1:0] pick;
      assign in_rng = (int'(fill) <= L) && (L < int'(fill) + int'(nbytes));
      assign pick   = CNT_W'(int'(nbytes) - 1 - L + int'(fill));
      assign hold_d[DATA_W-1-L*LANE_W -: LANE_W] =
         in_rng ? opnd[int'(pick)*LANE_W +: LANE_W] : hold_q[DATA_W-1-L*LANE_W -: LANE_W];
   end
endmodule

// File: rtl/dpk_extract.sv
// Presents the top lanes as a right-justified write operand and the left-shifted remainder.
module dpk_extract #(
   parameter int LANE_W = 8,
   parameter int LANES  = 4,
   parameter int CNT_W  = 3
) (
   input  logic [LANE_W*LANES-1:0] hold_q,
   input  logic [CNT_W-1:0]        nbytes,
   output logic [LANE_W*LANES-1:0] wr_data,
   output logic [LANE_W*LANES-1:0] hold_shift
);
   localparam int DATA_W = LANE_W * LANES;

   for (genvar j = 0; j < LANES; j++) begin : g_out
      assign wr_data[j*LANE_W +: LANE_W] = (j < int'(nbytes))
         ? hold_q[(LANES - int'(nbytes) + j)*LANE_W +: LANE_W] : '0;
   end

   for (genvar L = 0; L < LANES; L++) begin : g_shift
      assign hold_shift[DATA_W-1-L*LANE_W -: LANE_W] = (L + int'(nbytes) < LANES)
         ? hold_q[(LANES - 1 - L - int'(nbytes))*LANE_W +: LANE_W] : '0;
   end
endmodule

// File: rtl/dpk_fill.sv
// Byte occupancy counter; decides which side is served next.
module dpk_fill #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             abort,
   input  logic [CNT_W-1:0] src_n,
   input  logic [CNT_W-1:0] dst_n,
   input  logic             rd_valid,
   input  logic             wr_ack,
   output logic             rd_req,
   output logic             wr_req,
   output logic             rd_take,
   output logic             wr_take,
   output logic [CNT_W-1:0] fill
);
   assign rd_req  = fill < dst_n;
   assign wr_req  = ~rd_req;
   assign rd_take = rd_req & rd_valid;
   assign wr_take = wr_req & wr_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       fill <= '0;
      else if (abort)   fill <= '0;
      else if (rd_take) fill <= fill + src_n;
      else if (wr_take) fill <= fill - dst_n;
   end
endmodule

// File: rtl/dpk_holding_reg.sv
module dpk_holding_reg #(
   parameter int LANE_W = 8,
   parameter int LANES  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    abort,
   input  logic [1:0]              src_size,
   input  logic [1:0]              dst_size,
   output logic                    rd_req,
   input  logic                    rd_valid,
   input  logic [LANE_W*LANES-1:0] rd_data,
   output logic                    wr_req,
   input  logic                    wr_ack,
   output logic [LANE_W*LANES-1:0] wr_data,
   output logic [1:0]              wr_size
);
   import dpk_pkg::*;

   localparam int DATA_W = LANE_W * LANES;
   localparam int CNT_W  = $clog2(LANES + 1);

   if (LANES != 4 && LANES != 8) begin : g_bad_lanes
      $error("dpk_holding_reg: LANES must be 4 or 8");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("dpk_holding_reg: LANE_W must be positive");
   end

   logic [CNT_W-1:0]  src_n, dst_n, fill;
   logic              rd_take, wr_take;
   logic [DATA_W-1:0] hold_q, hold_ins, hold_shift;

   assign src_n = CNT_W'(code_to_bytes(src_size, LANES));
   assign dst_n = CNT_W'(code_to_bytes(dst_size, LANES));

   dpk_fill #(.CNT_W(CNT_W)) u_fill (
      .clk(clk), .rst_n(rst_n), .abort(abort), .src_n(src_n), .dst_n(dst_n),
      .rd_valid(rd_valid), .wr_ack(wr_ack), .rd_req(rd_req), .wr_req(wr_req),
      .rd_take(rd_take), .wr_take(wr_take), .fill(fill)
   );

   dpk_insert #(.LANE_W(LANE_W), .LANES(LANES), .CNT_W(CNT_W)) u_ins (
      .hold_q(hold_q), .fill(fill), .nbytes(src_n), .opnd(rd_data), .hold_d(hold_ins)
   );

   dpk_extract #(.LANE_W(LANE_W), .LANES(LANES), .CNT_W(CNT_W)) u_ext (
      .hold_q(hold_q), .nbytes(dst_n), .wr_data(wr_data), .hold_shift(hold_shift)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hold_q <= '0;
      else if (rd_take) hold_q <= hold_ins;
      else if (wr_take) hold_q <= hold_shift;
   end

   assign wr_size = dst_size;
endmodule

// File: rtl/dpk_holding_reg_chk.sv
module dpk_holding_reg_chk #(
   parameter int LANE_W = 8,
   parameter int LANES  = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    abort,
   input logic [1:0]              dst_size,
   input logic                    rd_req,
   input logic                    rd_valid,
   input logic                    wr_req,
   input logic                    wr_ack,
   input logic [LANE_W*LANES-1:0] wr_data
);
   localparam int DATA_W = LANE_W * LANES;

   // R6
   excl_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req && wr_req));

   // R1
   abort_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (rd_req && !wr_req));

   // R8
   hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !wr_ack && !abort) |=> (wr_req && $stable(wr_data)));

   // R7
   stray_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_req && !wr_ack && !abort) |=> (wr_req && $stable(wr_data)));

   // R2
   byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && dst_size == 2'd0) |-> (wr_data[DATA_W-1:LANE_W] == '0));

   // R2
   half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && dst_size == 2'd1) |-> (wr_data[DATA_W-1:2*LANE_W] == '0));
endmodule

bind dpk_holding_reg dpk_holding_reg_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
   .clk(clk), .rst_n(rst_n), .abort(abort), .dst_size(dst_size), .rd_req(rd_req),
   .rd_valid(rd_valid), .wr_req(wr_req), .wr_ack(wr_ack), .wr_data(wr_data)
);

// File: tb/dpk_holding_reg_tb.sv
module dpk_holding_reg_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        abort = 1'b0;
   logic [1:0]  src_size = 2'd0, dst_size = 2'd0;
   logic        rd_valid = 1'b0, wr_ack = 1'b0;
   logic [31:0] rd_data = '0;
   logic        rd_req, wr_req;
   logic [31:0] wr_data;
   logic [1:0]  wr_size;
   int n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;

   dpk_holding_reg u_dut (
      .clk(clk), .rst_n(rst_n), .abort(abort), .src_size(src_size), .dst_size(dst_size),
      .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
      .wr_req(wr_req), .wr_ack(wr_ack), .wr_data(wr_data), .wr_size(wr_size)
   );

   function automatic logic [7:0] sbyte(int n, int seed);
      return 8'((n * 37 + seed * 11 + 5) & 255);
   endfunction

   function automatic int nb(logic [1:0] c);
      return (c == 2'd3) ? 4 : (1 << c);
   endfunction

   task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] src_word(int first, int sn, int seed);
      logic [31:0] v = 32'hA5A5_A5A5;
      for (int k = 0; k < sn; k++) v[(sn-1-k)*8 +: 8] = sbyte(first + k, seed);
      return v;
   endfunction

   function automatic logic [31:0] dst_word(int first, int dn, int seed);
      logic [31:0] v = '0;
      for (int k = 0; k < dn; k++) v[(dn-1-k)*8 +: 8] = sbyte(first + k, seed);
      return v;
   endfunction

   task automatic run_combo(logic [1:0] s, logic [1:0] d);
      int sn = nb(s), dn = nb(d), seed = s * 4 + d + 1;
      int rcnt = 0, wcnt = 0, steps = 0;
      bit pw_idle = 0, stray = 0;
      string tag = (dn > sn) ? "R3" : ((dn < sn) ? "R4" : "R5");
      src_size = s; dst_size = d;
      while (wcnt < 8 && steps < 200) begin
         bit exp_w;
         @(negedge clk);
         rd_valid = 1'b0; wr_ack = 1'b0; rd_data = 32'h5A5A_5A5A;
         exp_w = (rcnt - wcnt) >= dn;
         check_eq(stray ? "R7" : "R6", {30'd0, rd_req, wr_req}, exp_w ? 32'd1 : 32'd2);
         stray = 0;
         if (wr_req && exp_w) begin
            check_eq(pw_idle ? "R8" : tag, wr_data, dst_word(wcnt, dn, seed));
            check_eq("R9", {30'd0, wr_size}, {30'd0, d});
            pw_idle = 0;
            if (steps % 5 == 3) pw_idle = 1;
            else if (steps % 7 == 2) begin rd_valid = 1'b1; rd_data = 32'hDEAD_BEEF; stray = 1; end
            else begin wr_ack = 1'b1; wcnt += dn; end
         end else if (rd_req && !exp_w) begin
            if (steps % 5 == 3) ;
            else if (steps % 7 == 2) begin wr_ack = 1'b1; stray = 1; end
            else begin rd_valid = 1'b1; rd_data = src_word(rcnt, sn, seed); rcnt += sn; end
         end
         steps++;
      end
      @(negedge clk);
      rd_valid = 1'b0; wr_ack = 1'b0;
      check_eq(tag, wcnt, 8);
      check_eq("R6", {30'd0, rd_req, wr_req}, 32'd2);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_eq("R1", {30'd0, rd_req, wr_req}, 32'd2);
      check_eq("R1", wr_data, 32'd0);

      for (int s = 0; s < 4; s++)
         for (int d = 0; d < 4; d++)
            run_combo(2'(s), 2'(d));

      // R10: abort after two of four bytes have been packed
      src_size = 2'd0; dst_size = 2'd2;
      for (int k = 0; k < 2; k++) begin
         @(negedge clk); rd_valid = 1'b1; rd_data = {24'hFFFFFF, 8'hE0 + 8'(k)};
      end
      @(negedge clk); rd_valid = 1'b0; abort = 1'b1;
      @(negedge clk); abort = 1'b0;
      check_eq("R1", {30'd0, rd_req, wr_req}, 32'd2);
      for (int k = 0; k < 4; k++) begin
         rd_valid = 1'b1; rd_data = {24'h0, sbyte(k, 9)};
         @(negedge clk);
      end
      rd_valid = 1'b0;
      check_eq("R10", {30'd0, rd_req, wr_req}, 32'd1);
      check_eq("R10", wr_data, dst_word(0, 4, 9));
      wr_ack = 1'b1;
      @(negedge clk); wr_ack = 1'b0;
      check_eq("R10", {30'd0, rd_req, wr_req}, 32'd2);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule